// File: doc/BRIEF.md
# Memory Fill Pattern Engine

This block writes a reproducible pseudo-random pattern into a contiguous range of memory words. It talks to a memory user port made of a command channel (valid, ready, write flag, word address) and a write-data channel (valid, ready, data). A single-cycle start pulse captures a base word address, a word count and a pattern mode. The engine then walks the range one word at a time: it issues a write command for the word and, once that command is taken, offers the pattern word on the data channel. When the last word has been transferred, done rises.

The pattern word for run index k is computed from the seed k. Each 32-bit chunk of a word is either a multiply-add hash of its sub-seed (scrambled mode) or the sub-seed itself (plain mode). A word of DATA_W bits holds DATA_W/32 chunks, so a later checker that knows only the base, the count and the mode can regenerate every expected word.

The controller is a four-state machine. IDLE is entered from reset. START_RUN (IDLE or FINISHED with start high) leads to ISSUE, or straight to FINISHED when the count is zero. CMD_TAKEN (ISSUE with cmd_ready) leads to WRITE. In WRITE, DATA_TAKEN leads back to ISSUE for the next word, or LAST_TAKEN leads to FINISHED after the final word. FINISHED holds done high until the next START_RUN. A one-cycle synchronous reset returns the machine to IDLE from any state.

Top module: `pattern_fill_engine`

## Requirements
- R1: While rst is high at a clock edge, and after that edge, cmd_valid, wd_valid and done are all 0.
- R2: A write command drives cmd_valid=1 with cmd_we=1 and cmd_addr = base + k (modulo 2^ADDR_W) for run word k, and keeps cmd_valid and cmd_addr unchanged until a cycle with cmd_ready high.
- R3: In the cycle after a command is accepted, wd_valid is 1 and wd_data holds the word for that k, unchanged until a cycle with wd_ready high; cmd_valid and wd_valid are never high together, so only one write is outstanding.
- R4: In scrambled mode (mode input 1), a chunk with sub-seed s equals (s * 0x31415979 + 1) mod 2^32; for DATA_W=64 and k=0 the word is 0x00000001_3141597A.
- R5: In plain mode (mode input 0), a chunk equals its sub-seed.
- R6: Word k consists of DATA_W/32 chunks; chunk i uses sub-seed k*(DATA_W/32)+i and sits in bits [DATA_W-1-32*i -: 32], so chunk 0 is the most significant; for DATA_W=64, plain mode, k=1 the word is 0x00000002_00000003.
- R7: done is 0 from the cycle after an accepted start until the last data transfer, becomes 1 in the cycle after that transfer, and stays 1 with no valid raised until the next accepted start.
- R8: A start with count 0 produces done=1 in the next cycle with no command issued.
- R9: A start pulse while a run is in progress (including the cycle of the final data transfer) is ignored: the run keeps its base and count and no extra command follows.
- R10: base, count and mode are captured on the start cycle; a start from IDLE or from the finished state begins a new run with exactly count commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins a run |
| base_in | input | ADDR_W | First word address of the run |
| count_in | input | LEN_W | Number of words to write |
| scramble_in | input | 1 | 1 = hashed pattern, 0 = plain sub-seed pattern |
| cmd_valid | output | 1 | Command channel valid |
| cmd_ready | input | 1 | Command channel ready |
| cmd_we | output | 1 | Command is a write |
| cmd_addr | output | ADDR_W | Command word address |
| wd_valid | output | 1 | Write-data channel valid |
| wd_ready | input | 1 | Write-data channel ready |
| wd_data | output | DATA_W | Pattern word |
| done | output | 1 | Run finished |

## Verification
The two functions that can share one cycle are the final data handshake of a run and the arrival of a new start pulse. The bench raises start in exactly the cycle where the memory model raises wd_ready for the last word, then checks that done rises in the next cycle, that no command appears, and that the number of commands equals the original count. A start in the middle of a run with a different base is judged the same way, with every command address still compared against the original base.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int unsigned CHUNK_W  = 32;
    localparam logic [31:0] HASH_MUL = 32'h3141_5979;
    localparam logic [31:0] HASH_ADD = 32'h0000_0001;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WRITE,
        ST_FINISHED
    } pf_state_e;
endpackage

// File: rtl/pf_chunk_hash.sv
module pf_chunk_hash
    import pf_pkg::*;
(
    input  logic [CHUNK_W-1:0] sub_seed,
    input  logic               scramble,
    output logic [CHUNK_W-1:0] chunk
);
    logic [CHUNK_W-1:0] hashed;

    always_comb begin
        hashed = sub_seed * HASH_MUL + HASH_ADD;
        chunk  = scramble ? hashed : sub_seed;
    end
endmodule

// File: rtl/pf_word_gen.sv
module pf_word_gen
    import pf_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [CHUNK_W-1:0] seed,
    input  logic               scramble,
    output logic [DATA_W-1:0]  word
);
    localparam int unsigned NCHUNK = DATA_W / CHUNK_W;

    for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
        logic [CHUNK_W-1:0] sub_seed;
        logic [CHUNK_W-1:0] chunk;

        assign sub_seed = seed * CHUNK_W'(NCHUNK) + CHUNK_W'(i);

        pf_chunk_hash u_hash (
            .sub_seed (sub_seed),
            .scramble (scramble),
            .chunk    (chunk)
        );

        assign word[DATA_W-1-CHUNK_W*i -: CHUNK_W] = chunk;
    end
endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
    import pf_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [LEN_W-1:0]  count_in,
    input  logic              scramble_in,
    input  logic              cmd_ready,
    input  logic              wd_ready,
    output logic              cmd_valid,
    output logic              cmd_we,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wd_valid,
    output logic              done,
    output logic [LEN_W-1:0]  word_idx,
    output logic              scramble_q
);
    pf_state_e         state, nxt;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  count_q;
    logic [LEN_W-1:0]  idx_inc;
    logic              accept;
    logic              last_word;

    assign idx_inc   = word_idx + LEN_W'(1);
    assign last_word = (idx_inc == count_q);
    assign accept    = start && (state == ST_IDLE || state == ST_FINISHED);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_FINISHED: if (start) nxt = (count_in == '0) ? ST_FINISHED : ST_ISSUE;
            ST_ISSUE:             if (cmd_ready) nxt = ST_WRITE;
            ST_WRITE:             if (wd_ready) nxt = last_word ? ST_FINISHED : ST_ISSUE;
            default:              nxt = ST_IDLE;
        endcase
    end

    // run registers
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q     <= '0;
            count_q    <= '0;
            scramble_q <= 1'b0;
            word_idx   <= '0;
        end else if (accept) begin
            base_q     <= base_in;
            count_q    <= count_in;
            scramble_q <= scramble_in;
            word_idx   <= '0;
        end else if (state == ST_WRITE && wd_ready) begin
            word_idx   <= idx_inc;
        end
    end

    // outputs
    always_comb begin
        cmd_valid = 1'b0;
        cmd_we    = 1'b0;
        wd_valid  = 1'b0;
        done      = 1'b0;
        cmd_addr  = base_q + ADDR_W'(word_idx);
        unique case (state)
            ST_IDLE:     ;
            ST_ISSUE:    begin cmd_valid = 1'b1; cmd_we = 1'b1; end
            ST_WRITE:    wd_valid = 1'b1;
            ST_FINISHED: done = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/pattern_fill_engine.sv
module pattern_fill_engine
    import pf_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [LEN_W-1:0]  count_in,
    input  logic              scramble_in,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_we,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wd_valid,
    input  logic              wd_ready,
    output logic [DATA_W-1:0] wd_data,
    output logic              done
);
    logic [LEN_W-1:0]   word_idx;
    logic               scramble_q;
    logic [CHUNK_W-1:0] seed;

    assign seed = CHUNK_W'(word_idx);

    pf_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .base_in     (base_in),
        .count_in    (count_in),
        .scramble_in (scramble_in),
        .cmd_ready   (cmd_ready),
        .wd_ready    (wd_ready),
        .cmd_valid   (cmd_valid),
        .cmd_we      (cmd_we),
        .cmd_addr    (cmd_addr),
        .wd_valid    (wd_valid),
        .done        (done),
        .word_idx    (word_idx),
        .scramble_q  (scramble_q)
    );

    pf_word_gen #(.DATA_W(DATA_W)) u_word (
        .seed     (seed),
        .scramble (scramble_q),
        .word     (wd_data)
    );
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LEN_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W-1:0] base_in,
    input logic [LEN_W-1:0]  count_in,
    input logic              scramble_in,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_we,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              wd_valid,
    input logic              wd_ready,
    input logic [DATA_W-1:0] wd_data,
    input logic              done
);
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cmd_valid && !wd_valid && !done)); // R1
    AST_CMD_IS_WRITE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_we); // R2
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr))); // R2
    AST_DATA_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> wd_valid); // R3
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wd_valid && !wd_ready) |=> (wd_valid && $stable(wd_data))); // R3
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && wd_valid)); // R3
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!cmd_valid && !wd_valid)); // R7
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (start && !cmd_valid && !wd_valid && count_in == '0) |=> (done && !cmd_valid)); // R8
endmodule

bind pattern_fill_engine pf_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_pf_checker (.*);

// File: tb/test_pattern_fill_engine.sv
module test_pattern_fill_engine;
    localparam int unsigned DW = 64;
    localparam int unsigned AW = 16;
    localparam int unsigned LW = 12;
    localparam int unsigned CH = DW / 32;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [LW-1:0] count;
        logic          scr;
        logic [3:0]    cdly;
        logic [3:0]    wdly;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0100, 12'd4, 1'b1, 4'd0, 4'd0},
        '{16'h0FFE, 12'd5, 1'b0, 4'd2, 4'd1},
        '{16'hFFFE, 12'd4, 1'b1, 4'd1, 4'd3},
        '{16'h0000, 12'd1, 1'b0, 4'd0, 4'd2},
        '{16'h1234, 12'd9, 1'b1, 4'd3, 4'd0},
        '{16'h0040, 12'd3, 1'b0, 4'd0, 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] base_in = '0;
    logic [LW-1:0] count_in = '0;
    logic          scramble_in = 1'b0;
    logic          cmd_valid, cmd_we, wd_valid, done;
    logic          cmd_ready = 1'b0;
    logic          wd_ready = 1'b0;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] wd_data;

    int n_chk = 0;
    int n_fail = 0;

    // memory model state
    int            cdly = 0, wdly = 0, ccnt = 0, wcnt = 0;
    int            k = 0, cmd_seen = 0;
    logic [AW-1:0] run_base = '0;
    logic          run_scr = 1'b0;
    logic [DW-1:0] cap [16];

    always #10 clk = ~clk;

    pattern_fill_engine #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW)) i_pattern_fill_engine (
        .clk(clk), .rst(rst), .start(start), .base_in(base_in), .count_in(count_in),
        .scramble_in(scramble_in), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_we(cmd_we), .cmd_addr(cmd_addr), .wd_valid(wd_valid), .wd_ready(wd_ready),
        .wd_data(wd_data), .done(done)
    );

    function automatic logic [DW-1:0] exp_word(int unsigned idx, bit scr);
        logic [31:0] sub;
        logic [DW-1:0] w = '0;
        for (int i = 0; i < CH; i++) begin
            sub = 32'(idx * CH + i);
            w[DW-1-32*i -: 32] = scr ? (sub * 32'h3141_5979 + 32'd1) : sub;
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: ready after a programmed number of wait cycles
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                cmd_ready = 1'b0; wd_ready = 1'b0; ccnt = 0; wcnt = 0;
            end else begin
                if (cmd_ready) begin
                    cmd_ready = 1'b0; ccnt = 0;
                end else if (cmd_valid) begin
                    if (ccnt >= cdly) begin
                        chk(cmd_we === 1'b1 && cmd_addr === AW'(run_base + AW'(k)),
                            "R2 command address", DW'(cmd_addr), DW'(AW'(run_base + AW'(k))));
                        cmd_ready = 1'b1; cmd_seen++;
                    end else ccnt++;
                end
                if (wd_ready) begin
                    wd_ready = 1'b0; wcnt = 0;
                end else if (wd_valid) begin
                    if (wcnt >= wdly) begin
                        chk(wd_data === exp_word(k, run_scr), "R4 R5 R6 pattern word",
                            wd_data, exp_word(k, run_scr));
                        if (k < 16) cap[k] = wd_data;
                        wd_ready = 1'b1; k++;
                    end else wcnt++;
                end
            end
        end
    end

    task automatic pulse_start(input logic [AW-1:0] b, input logic [LW-1:0] n, input logic s);
        @(negedge clk); #1;
        start = 1'b1; base_in = b; count_in = n; scramble_in = s;
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic begin_run(input vec_t v);
        cdly = int'(v.cdly); wdly = int'(v.wdly);
        run_base = v.base; run_scr = v.scr; k = 0; cmd_seen = 0;
        pulse_start(v.base, v.count, v.scr);
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (done !== 1'b1 && n < 2000) begin
            @(negedge clk); #1; n++;
        end
        chk(done === 1'b1, tag, DW'(done), DW'(1));
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        vec_t v;
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(!cmd_valid && !wd_valid && !done, "R1 outputs in reset", DW'({cmd_valid, wd_valid, done}), '0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(!cmd_valid && !wd_valid && !done, "R1 idle after reset", DW'({cmd_valid, wd_valid, done}), '0);

        // table of runs, each starting from idle or finished (R10)
        for (int r = 0; r < NVEC; r++) begin
            v = VECS[r];
            begin_run(v);
            chk(done === 1'b0, "R7 done low during run", DW'(done), '0);
            wait_done("R7 done after run");
            chk(cmd_seen == int'(v.count) && k == int'(v.count), "R10 command count",
                DW'(cmd_seen), DW'(v.count));
            repeat (3) @(negedge clk);
            #1;
            chk(done && !cmd_valid && !wd_valid, "R7 done holds quietly", DW'({done, cmd_valid, wd_valid}), DW'(3'b100));
        end

        // R4 literal: scrambled word k=0
        begin_run('{16'h0500, 12'd2, 1'b1, 4'd0, 4'd0});
        wait_done("R7 done scrambled run");
        chk(cap[0] === 64'h0000_0001_3141_597A, "R4 scrambled word k0", cap[0], 64'h0000_0001_3141_597A);

        // R5/R6 literal: plain word k=1
        begin_run('{16'h0200, 12'd2, 1'b0, 4'd1, 4'd1});
        wait_done("R7 done plain run");
        chk(cap[1] === 64'h0000_0002_0000_0003, "R5 R6 plain word k1 chunk order", cap[1], 64'h0000_0002_0000_0003);

        // R8: zero count
        begin_run('{16'h0300, 12'd0, 1'b1, 4'd0, 4'd0});
        chk(done === 1'b1 && !cmd_valid, "R8 zero count done at once", DW'({done, cmd_valid}), DW'(2'b10));
        repeat (4) @(negedge clk);
        #1;
        chk(cmd_seen == 0, "R8 zero count no command", DW'(cmd_seen), '0);

        // R9: start in the middle of a run is ignored
        begin_run('{16'h0300, 12'd6, 1'b0, 4'd1, 4'd1});
        repeat (3) @(negedge clk);
        pulse_start(16'h0700, 12'd2, 1'b1);
        wait_done("R9 done after mid-run start");
        chk(cmd_seen == 6, "R9 mid-run start ignored", DW'(cmd_seen), DW'(6));

        // R9: start coinciding with the final data handshake
        begin_run('{16'h0A00, 12'd3, 1'b1, 4'd0, 4'd2});
        while (!(wd_ready && k == 3)) begin
            @(negedge clk); #1;
        end
        start = 1'b1; base_in = 16'h0900; count_in = 12'd3;
        @(negedge clk); #1;
        start = 1'b0;
        chk(done === 1'b1 && !cmd_valid, "R9 start on last transfer ignored", DW'({done, cmd_valid}), DW'(2'b10));
        repeat (5) @(negedge clk);
        #1;
        chk(cmd_seen == 3 && done === 1'b1, "R9 no extra command", DW'(cmd_seen), DW'(3));

        // R1: reset in the middle of a run
        begin_run('{16'h0800, 12'd8, 1'b1, 4'd2, 4'd2});
        repeat (5) @(negedge clk);
        #1;
        rst = 1'b1;
        @(negedge clk); #1;
        rst = 1'b0;
        chk(!cmd_valid && !wd_valid && !done, "R1 mid-run reset", DW'({cmd_valid, wd_valid, done}), '0);
        @(negedge clk); #1;
        chk(!cmd_valid && !wd_valid && !done, "R1 stays idle", DW'({cmd_valid, wd_valid, done}), '0);

        // R10: new run after reset
        begin_run('{16'h0C00, 12'd3, 1'b0, 4'd0, 4'd1});
        wait_done("R10 done after reset run");
        chk(cmd_seen == 3, "R10 run after reset", DW'(cmd_seen), DW'(3));

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule